// File: doc/BRIEF.md
# Mode Register Load Decoder

This block sits on the device side of a double-data-rate SDRAM command path. It watches for load-mode-register commands. On each load, a one-bit register select, taken from bank-address bit 0, picks either the base mode register or the extended mode register. The address bus carries the value to be loaded.

For a base load, the block splits the address into two parts. The upper operating-mode bits are classified as normal operation, DLL reset, or reserved. The lower bits carry the burst length, burst type and CAS latency fields. Illegal loads are rejected as a whole and reported on an error pulse. For an extended load, the block takes the DLL enable and the output drive strength.

The block also follows the recommended programming order. After a DLL-reset load, the next load should be a plain normal-mode load. Any other load in that position raises a warning pulse.

Every output is a register, so each result shows up on the cycle after the load edge.

Top module: `modereg_loader`

## Requirements
- R1: After synchronous reset the outputs are as follows: `burst_len` is 2, `burst_interleave` is 0, `cas_x2` is 5 (latency 2.5), `dll_enable` is 1, `drive_reduced` is 0, and all pulses are low. No DLL reset is pending, so the first load after reset never warns.
- R2: A load with `mr_select`=0, address bits 12..7 all zero and legal fields is applied. Bits 2..0 give the burst length (001 gives `burst_len`=2, 010 gives 4, 011 gives 8). Bit 3 gives `burst_interleave`. Bits 6..4 give the CAS latency (010 gives `cas_x2`=4, 110 gives `cas_x2`=5). The new values appear on the cycle after the load edge.
- R3: A base load with bit 8 set, bits 12..9 and bit 7 clear, and legal fields applies the fields like R2. It also raises `dll_reset_pulse` for exactly one cycle.
- R4: A base load whose bits 12..7 are neither all zero nor exactly bit 8 raises `mode_error` for one cycle. It changes no configuration output and gives no `dll_reset_pulse`.
- R5: A base load with a normal or DLL-reset pattern but an illegal burst-length code (000 or 100..111) or an illegal CAS code (anything other than 010 or 110) is rejected the same way as in R4.
- R6: A load with `mr_select`=1 and bits 12..2 clear sets `dll_enable` to the inverse of bit 0 and `drive_reduced` to bit 1. It leaves the base fields unchanged. A base load leaves `dll_enable` and `drive_reduced` unchanged.
- R7: An extended load with any of bits 12..2 set raises `mode_error` for one cycle and changes nothing.
- R8: An accepted DLL-reset load makes a DLL reset pending. While it is pending, every load that is not an accepted normal-mode base load raises `seq_warn` for one cycle, and the reset stays pending.
- R9: An accepted normal-mode base load while a reset is pending raises no warning and clears the pending state. Later loads do not warn until the next accepted DLL-reset load.
- R10: In cycles without a load, every configuration output holds its value and all three pulses stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_valid | input | 1 | A load-mode-register command is present this cycle |
| mr_select | input | 1 | Register select: 0 for base, 1 for extended (bank-address bit 0) |
| load_addr | input | ADDR_W | Value carried on the address bus with the load |
| burst_len | output | 4 | Current burst length (2, 4 or 8) |
| burst_interleave | output | 1 | 1 for interleaved burst order, 0 for sequential |
| cas_x2 | output | 3 | CAS latency in half cycles (4 or 5) |
| dll_reset_pulse | output | 1 | One-cycle pulse after an accepted DLL-reset load |
| dll_enable | output | 1 | DLL enabled |
| drive_reduced | output | 1 | Reduced output drive strength selected |
| mode_error | output | 1 | One-cycle pulse after a rejected load |
| seq_warn | output | 1 | One-cycle pulse after a load that breaks the DLL-reset sequence |

## Verification
The hardest condition to reach from the ports is a second rejected or out-of-order load while a DLL reset is still pending. In that case the error pulse and the warning pulse must both fire, and the pending state must survive. The sweep drives all 8192 combinations of operating-mode pattern and field value through the base register. Once the first DLL-reset pattern is accepted, every later load in the sweep arrives with a reset pending. A directed sequence afterwards mixes extended, reserved and normal loads to show exactly when the pending state clears.

// File: rtl/mrl_pkg.sv
package mrl_pkg;

  // Base register field layout (bit positions matter to the decode)
  localparam int BL_LSB      = 0;
  localparam int BL_W        = 3;
  localparam int BT_BIT      = 3;
  localparam int CL_LSB      = 4;
  localparam int CL_W        = 3;
  localparam int OP_LSB      = 7;
  localparam int DLL_RST_BIT = 8;

  // Extended register layout
  localparam int EXT_DLL_OFF_BIT = 0;
  localparam int EXT_DRV_BIT     = 1;
  localparam int EXT_USED        = 2;

  localparam logic [BL_W-1:0] BL_CODE_2  = 3'b001;
  localparam logic [BL_W-1:0] BL_CODE_8  = 3'b011;
  localparam logic [CL_W-1:0] CL_CODE_2  = 3'b010;
  localparam logic [CL_W-1:0] CL_CODE_25 = 3'b110;

  typedef enum logic [1:0] {
    OPM_NORMAL   = 2'd0,
    OPM_DLL_RST  = 2'd1,
    OPM_RESERVED = 2'd2
  } opmode_e;

  typedef struct packed {
    logic [BL_W-1:0] bl_code;
    logic            interleave;
    logic [CL_W-1:0] cl_code;
  } base_cfg_t;

  typedef struct packed {
    logic dll_off;
    logic drv_reduced;
  } ext_cfg_t;

  function automatic logic [3:0] bl_to_len(input logic [BL_W-1:0] code);
    return 4'd1 << code[1:0];
  endfunction

  function automatic logic [2:0] cl_to_half(input logic [CL_W-1:0] code);
    return (code == CL_CODE_2) ? 3'd4 : 3'd5;
  endfunction

endpackage

// File: rtl/mrl_base_decode.sv
module mrl_base_decode
  import mrl_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output opmode_e           opmode,
  output base_cfg_t         cfg,
  output logic              fields_ok
);
  localparam int OPW = ADDR_W - OP_LSB;
  localparam logic [OPW-1:0] DLL_PATTERN = OPW'(1) << (DLL_RST_BIT - OP_LSB);

  logic [OPW-1:0] op_bits;
  logic           bl_ok;
  logic           cl_ok;

  assign op_bits = addr[ADDR_W-1:OP_LSB];

  always_comb begin
    if (op_bits == '0)              opmode = OPM_NORMAL;
    else if (op_bits == DLL_PATTERN) opmode = OPM_DLL_RST;
    else                             opmode = OPM_RESERVED;
  end

  assign cfg.bl_code    = addr[BL_LSB +: BL_W];
  assign cfg.interleave = addr[BT_BIT];
  assign cfg.cl_code    = addr[CL_LSB +: CL_W];

  assign bl_ok     = (cfg.bl_code >= BL_CODE_2) && (cfg.bl_code <= BL_CODE_8);
  assign cl_ok     = (cfg.cl_code == CL_CODE_2) || (cfg.cl_code == CL_CODE_25);
  assign fields_ok = bl_ok && cl_ok;
endmodule

// File: rtl/mrl_ext_decode.sv
module mrl_ext_decode
  import mrl_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output ext_cfg_t          cfg,
  output logic              ext_ok
);
  localparam int RSV_W = ADDR_W - EXT_USED;

  logic [RSV_W-1:0] rsv_hit;

  // one detector per reserved extended bit
  for (genvar i = 0; i < RSV_W; i++) begin : g_rsv
    assign rsv_hit[i] = addr[EXT_USED + i];
  end

  assign cfg.dll_off     = addr[EXT_DLL_OFF_BIT];
  assign cfg.drv_reduced = addr[EXT_DRV_BIT];
  assign ext_ok          = (rsv_hit == '0);
endmodule

// File: rtl/mrl_seq_tracker.sv
module mrl_seq_tracker (
  input  logic clk,
  input  logic rst,
  input  logic load_valid,
  input  logic normal_accepted,
  input  logic dll_accepted,
  output logic seq_warn,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      seq_warn <= 1'b0;
    end else begin
      seq_warn <= load_valid && pending && !normal_accepted;
      if (dll_accepted)         pending <= 1'b1;
      else if (normal_accepted) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/modereg_loader.sv
module modereg_loader
  import mrl_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_valid,
  input  logic              mr_select,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [3:0]        burst_len,
  output logic              burst_interleave,
  output logic [2:0]        cas_x2,
  output logic              dll_reset_pulse,
  output logic              dll_enable,
  output logic              drive_reduced,
  output logic              mode_error,
  output logic              seq_warn
);
  opmode_e   opmode;
  base_cfg_t base_cfg;
  logic      fields_ok;
  ext_cfg_t  ext_cfg;
  logic      ext_ok;
  logic      base_load;
  logic      ext_load;
  logic      base_accept;
  logic      normal_accepted;
  logic      dll_accepted;
  logic      pending;

  mrl_base_decode #(.ADDR_W(ADDR_W)) u_base (
    .addr      (load_addr),
    .opmode    (opmode),
    .cfg       (base_cfg),
    .fields_ok (fields_ok)
  );

  mrl_ext_decode #(.ADDR_W(ADDR_W)) u_ext (
    .addr   (load_addr),
    .cfg    (ext_cfg),
    .ext_ok (ext_ok)
  );

  assign base_load       = load_valid && !mr_select;
  assign ext_load        = load_valid && mr_select;
  assign base_accept     = base_load && fields_ok && (opmode != OPM_RESERVED);
  assign normal_accepted = base_accept && (opmode == OPM_NORMAL);
  assign dll_accepted    = base_accept && (opmode == OPM_DLL_RST);

  mrl_seq_tracker u_seq (
    .clk             (clk),
    .rst             (rst),
    .load_valid      (load_valid),
    .normal_accepted (normal_accepted),
    .dll_accepted    (dll_accepted),
    .seq_warn        (seq_warn),
    .pending         (pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_len        <= bl_to_len(BL_CODE_2);
      burst_interleave <= 1'b0;
      cas_x2           <= cl_to_half(CL_CODE_25);
      dll_enable       <= 1'b1;
      drive_reduced    <= 1'b0;
      dll_reset_pulse  <= 1'b0;
      mode_error       <= 1'b0;
    end else begin
      dll_reset_pulse <= dll_accepted;
      mode_error      <= (base_load && !base_accept) || (ext_load && !ext_ok);
      if (base_accept) begin
        burst_len        <= bl_to_len(base_cfg.bl_code);
        burst_interleave <= base_cfg.interleave;
        cas_x2           <= cl_to_half(base_cfg.cl_code);
      end
      if (ext_load && ext_ok) begin
        dll_enable    <= !ext_cfg.dll_off;
        drive_reduced <= ext_cfg.drv_reduced;
      end
    end
  end
endmodule

// File: rtl/modereg_loader_checker.sv
module modereg_loader_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              load_valid,
  input logic              mr_select,
  input logic [ADDR_W-1:0] load_addr,
  input logic [3:0]        burst_len,
  input logic              burst_interleave,
  input logic [2:0]        cas_x2,
  input logic              dll_reset_pulse,
  input logic              dll_enable,
  input logic              drive_reduced,
  input logic              mode_error,
  input logic              seq_warn
);
  assert_bl_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (burst_len == 4'd2) || (burst_len == 4'd4) || (burst_len == 4'd8));

  assert_cl_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (cas_x2 == 3'd4) || (cas_x2 == 3'd5));

  assert_pulse_after_load_R3: assert property (@(posedge clk) disable iff (rst)
    dll_reset_pulse |-> ($past(load_valid) && !$past(mr_select)));

  assert_err_after_load_R4: assert property (@(posedge clk) disable iff (rst)
    mode_error |-> $past(load_valid));

  assert_err_excl_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    !(mode_error && dll_reset_pulse));

  assert_ext_hold_on_base_R6: assert property (@(posedge clk) disable iff (rst)
    (load_valid && !mr_select) |=> ($stable(dll_enable) && $stable(drive_reduced)));

  assert_warn_after_load_R8: assert property (@(posedge clk) disable iff (rst)
    seq_warn |-> $past(load_valid));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !load_valid |=> ($stable(burst_len) && $stable(burst_interleave) && $stable(cas_x2)
                     && $stable(dll_enable) && $stable(drive_reduced)));

  assert_addr_known_R2: assert property (@(posedge clk) disable iff (rst)
    load_valid |-> !$isunknown(load_addr));
endmodule

bind modereg_loader modereg_loader_checker #(.ADDR_W(ADDR_W)) u_checker (.*);

// File: tb/modereg_loader_test.sv
module modereg_loader_test;
  localparam int ADDR_W = 13;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              load_valid = 1'b0;
  logic              mr_select = 1'b0;
  logic [ADDR_W-1:0] load_addr = '0;
  logic [3:0]        burst_len;
  logic              burst_interleave;
  logic [2:0]        cas_x2;
  logic              dll_reset_pulse;
  logic              dll_enable;
  logic              drive_reduced;
  logic              mode_error;
  logic              seq_warn;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  // reference model state
  int  m_len, m_bt, m_cas, m_dll, m_drv;
  bit  m_pending;

  always #4 clk = ~clk;

  modereg_loader #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .load_valid(load_valid), .mr_select(mr_select),
    .load_addr(load_addr), .burst_len(burst_len), .burst_interleave(burst_interleave),
    .cas_x2(cas_x2), .dll_reset_pulse(dll_reset_pulse), .dll_enable(dll_enable),
    .drive_reduced(drive_reduced), .mode_error(mode_error), .seq_warn(seq_warn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_len = 2; m_bt = 0; m_cas = 5; m_dll = 1; m_drv = 0; m_pending = 1'b0;
  endtask

  task automatic check_cfg(input string tag);
    chk({tag, " burst_len"}, int'(burst_len), m_len);
    chk({tag, " interleave"}, int'(burst_interleave), m_bt);
    chk({tag, " cas_x2"}, int'(cas_x2), m_cas);
    chk({tag, " dll_enable"}, int'(dll_enable), m_dll);
    chk({tag, " drive"}, int'(drive_reduced), m_drv);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; load_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
    #1;
    check_cfg("R1");
    chk("R1 pulse", int'(dll_reset_pulse), 0);
    chk("R1 error", int'(mode_error), 0);
    chk("R1 warn", int'(seq_warn), 0);
  endtask

  task automatic do_load(input bit sel, input logic [ADDR_W-1:0] a);
    int    op, bl, cl;
    bit    accept, normal, dll;
    string tag, wtag;
    @(negedge clk);
    load_valid = 1'b1; mr_select = sel; load_addr = a;
    @(negedge clk);
    load_valid = 1'b0;
    #1;
    op = int'(a[12:7]); bl = int'(a[2:0]); cl = int'(a[6:4]);
    normal = 1'b0; dll = 1'b0;
    if (!sel) begin
      accept = (op == 0 || op == 2) && (bl >= 1 && bl <= 3) && (cl == 2 || cl == 6);
      if (op != 0 && op != 2) tag = "R4";
      else if (!accept)       tag = "R5";
      else if (op == 2)       tag = "R3";
      else                    tag = "R2";
      if (accept) begin
        m_len = 1 << bl; m_bt = int'(a[3]); m_cas = (cl == 2) ? 4 : 5;
        normal = (op == 0); dll = (op == 2);
      end
    end else begin
      accept = (a[12:2] == '0);
      tag = accept ? "R6" : "R7";
      if (accept) begin
        m_dll = a[0] ? 0 : 1; m_drv = int'(a[1]);
      end
    end
    wtag = m_pending ? "R8" : "R9";
    check_cfg(tag);
    chk({tag, " error"}, int'(mode_error), accept ? 0 : 1);
    chk({tag, " dll pulse R3"}, int'(dll_reset_pulse), dll ? 1 : 0);
    chk({wtag, " warn"}, int'(seq_warn), (m_pending && !normal) ? 1 : 0);
    if (dll) m_pending = 1'b1;
    else if (normal) m_pending = 1'b0;
  endtask

  task automatic idle_check();
    @(negedge clk); #1;
    check_cfg("R10");
    chk("R10 pulse", int'(dll_reset_pulse), 0);
    chk("R10 error", int'(mode_error), 0);
    chk("R10 warn", int'(seq_warn), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    model_reset();
    do_reset();
    // R1: the first load after reset does not warn
    do_load(1'b1, 13'h0000);
    // exhaustive sweep of base loads, pending sets at first DLL-reset load (R8)
    for (int op = 0; op < 64; op++) begin
      for (int lo = 0; lo < 128; lo++) begin
        do_load(1'b0, {op[5:0], lo[6:0]});
      end
    end
    idle_check();
    // directed sequence for R8 / R9
    do_reset();
    do_load(1'b0, {6'b000010, 7'b010_0_010});   // DLL reset, BL4, CL2
    do_load(1'b1, 13'h0002);                     // ext while pending -> warn
    do_load(1'b0, {6'b000100, 7'b110_1_011});    // reserved -> error + warn
    do_load(1'b0, {6'b000000, 7'b000_0_001});    // bad CL -> error + warn
    do_load(1'b0, {6'b000010, 7'b110_0_001});    // DLL reset again -> warn
    do_load(1'b0, {6'b000000, 7'b110_1_011});    // normal -> clears, R9
    do_load(1'b1, 13'h0001);                     // no warn now
    do_load(1'b0, {6'b000000, 7'b010_0_010});
    idle_check();
    idle_check();
    // extended register sweep (R6, R7)
    for (int i = 0; i < 16; i++) begin
      do_load(1'b1, 13'(i));
    end
    for (int b = 2; b < ADDR_W; b++) begin
      do_load(1'b1, (13'd1 << b) | 13'd3);
      do_load(1'b1, 13'd0);
    end
    idle_check();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule